// File: doc/BRIEF.md
# Receive Bit Error Rate Checker

This block is the receive half of a bit error rate tester. A serial line delivers one bit per strobe. The block holds a local reference built from the 15-stage pseudorandom polynomial x^15 + x^14 + 1. While it hunts for the pattern, it loads that reference from the bits it receives. After the stream has followed the predicted sequence for long enough, the reference runs free. From then on, each received bit that differs from the prediction counts as a bit error.

Two saturating counters record the result. One counts every received bit. The other counts the bit errors seen while the block is locked. A sliding window over the most recent locked bits decides when lock is lost. A separate run detector reports a line stuck at zero. The host reads the counters directly and clears them with one synchronous input.

Top module: `bert_rx_sync`

## Requirements
- R1: While reset is asserted, in_sync, all_zeros, every pulse output and both counters are 0. On the first clock edge after reset is released, search_start pulses high for exactly one cycle.
- R2: The reference is a 15-bit register `r`, with the newest bit in r[0]. The predicted bit is r[14] XOR r[13]. On each valid bit the register shifts left. While searching, the received bit is shifted in. While locked, the predicted bit is shifted in.
- R3: While searching, a valid bit that equals the prediction adds one to a run of matches, and a valid bit that differs resets the run to zero. When the run reaches 32, in_sync goes high one cycle after that bit. in_sync is a live level and is never latched.
- R4: While locked, a valid bit that differs from the prediction is a bit error. err_det pulses high for one cycle after that bit.
- R5: The loss window holds the most recent 64 valid bits received since lock, including the current bit, and starts empty at each lock. When the window holds 6 or more errors, in_sync falls one cycle after that bit and search_start pulses in the same cycle.
- R6: err_cnt counts bit errors only while locked and saturates at 2^ERR_CNT_W-1. err_sat pulses for one cycle when err_cnt reaches that value, and not again until the counter has been cleared.
- R7: bit_cnt counts every valid bit and saturates at 2^BIT_CNT_W-1. bit_sat pulses for one cycle when bit_cnt reaches that value.
- R8: cnt_clr zeroes both counters on the next cycle and takes priority over any increment in that cycle. After a clear, each counter can saturate again and raise its pulse again.
- R9: all_zeros goes high one cycle after the 31st consecutive valid zero. It goes low one cycle after a valid one is received. Cycles without a valid bit neither extend nor break the run.
- R10: A cycle with bit_vld low changes neither the lock state nor the reference nor either counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | Marks bit_in as a valid received bit this cycle |
| bit_in | input | 1 | Received serial data |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| in_sync | output | 1 | Live lock indication |
| search_start | output | 1 | One-cycle pulse when pattern hunting begins |
| err_det | output | 1 | One-cycle pulse per bit error detected while locked |
| bit_sat | output | 1 | One-cycle pulse when the bit counter saturates |
| err_sat | output | 1 | One-cycle pulse when the error counter saturates |
| all_zeros | output | 1 | Level: a run of at least 31 zeros is in progress |
| bit_cnt | output | BIT_CNT_W (32) | Saturating count of received bits |
| err_cnt | output | ERR_CNT_W (24) | Saturating count of bit errors |

## Verification
A clean pseudorandom stream shows that self-seeding and the lock rule work. Because the first 15 bits are predicted from an empty register, the exact lock cycle also reveals an error in the tap or shift direction. A stream carrying five errors within 64 bits is set against one carrying six, which places the loss threshold exactly. Random bits fed in while searching show that errors are counted only in lock. A stream with one error every 16 bits stays locked and drives the error counter through saturation, both before and after a clear. A run of 31 zeros broken by idle cycles and then by a one shows that the run detector responds only to valid bits.

// File: rtl/bert_rx_sync.sv
module bert_rx_sync #(
  parameter int BIT_CNT_W = 32,
  parameter int ERR_CNT_W = 24,
  parameter int PRBS_W    = 15,
  parameter int PRBS_TAP  = 14,
  parameter int LOCK_RUN  = 32,
  parameter int WIN_LEN   = 64,
  parameter int LOSS_ERRS = 6,
  parameter int ZERO_RUN  = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_vld,
  input  logic                 bit_in,
  input  logic                 cnt_clr,
  output logic                 in_sync,
  output logic                 search_start,
  output logic                 err_det,
  output logic                 bit_sat,
  output logic                 err_sat,
  output logic                 all_zeros,
  output logic [BIT_CNT_W-1:0] bit_cnt,
  output logic [ERR_CNT_W-1:0] err_cnt
);

  localparam int MC_W = $clog2(LOCK_RUN + 1);
  localparam int PC_W = $clog2(WIN_LEN + 1);
  localparam int ZR_W = $clog2(ZERO_RUN + 1);
  localparam logic [MC_W-1:0]      LOCK_LAST = MC_W'(LOCK_RUN - 1);
  localparam logic [PC_W-1:0]      LOSS_LIM  = PC_W'(LOSS_ERRS);
  localparam logic [ZR_W-1:0]      ZR_TOP    = ZR_W'(ZERO_RUN);
  localparam logic [BIT_CNT_W-1:0] BIT_TOP   = '1;
  localparam logic [BIT_CNT_W-1:0] BIT_NEAR  = BIT_TOP - 1'b1;
  localparam logic [ERR_CNT_W-1:0] ERR_TOP   = '1;
  localparam logic [ERR_CNT_W-1:0] ERR_NEAR  = ERR_TOP - 1'b1;

  logic [PRBS_W-1:0]  ref_q;
  logic [MC_W-1:0]    run_q;
  logic [WIN_LEN-1:0] hist_q;
  logic [PC_W-1:0]    pop_q;
  logic [ZR_W-1:0]    zrun_q;
  logic               boot_q;

  wire pred = ref_q[PRBS_W-1] ^ ref_q[PRBS_TAP-1];
  wire miss = bit_in ^ pred;
  wire [PC_W-1:0] pop_nxt = pop_q + PC_W'(miss) - PC_W'(hist_q[WIN_LEN-1]);
  wire lose   = in_sync & bit_vld & (pop_nxt >= LOSS_LIM);
  wire gain   = !in_sync & bit_vld & !miss & (run_q == LOCK_LAST);
  wire hit    = in_sync & bit_vld & miss;

  assign all_zeros = (zrun_q == ZR_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q       <= 1'b1;
      search_start <= 1'b0;
      err_det      <= 1'b0;
      in_sync      <= 1'b0;
      ref_q        <= '0;
      run_q        <= '0;
      hist_q       <= '0;
      pop_q        <= '0;
      zrun_q       <= '0;
    end else begin
      boot_q       <= 1'b0;
      search_start <= boot_q | lose;
      err_det      <= hit;
      if (bit_vld) begin
        ref_q  <= {ref_q[PRBS_W-2:0], in_sync ? pred : bit_in};
        zrun_q <= bit_in ? '0 : (all_zeros ? zrun_q : zrun_q + 1'b1);
        if (lose) begin
          in_sync <= 1'b0;
          run_q   <= '0;
          hist_q  <= '0;
          pop_q   <= '0;
        end else if (in_sync) begin
          hist_q <= {hist_q[WIN_LEN-2:0], miss};
          pop_q  <= pop_nxt;
        end else if (gain) begin
          in_sync <= 1'b1;
          run_q   <= '0;
          hist_q  <= '0;
          pop_q   <= '0;
        end else begin
          run_q <= miss ? '0 : run_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      err_cnt <= '0;
      bit_sat <= 1'b0;
      err_sat <= 1'b0;
    end else begin
      bit_sat <= 1'b0;
      err_sat <= 1'b0;
      if (cnt_clr) begin
        bit_cnt <= '0;
        err_cnt <= '0;
      end else begin
        if (bit_vld && bit_cnt != BIT_TOP) begin
          bit_cnt <= bit_cnt + 1'b1;
          bit_sat <= (bit_cnt == BIT_NEAR);
        end
        if (hit && err_cnt != ERR_TOP) begin
          err_cnt <= err_cnt + 1'b1;
          err_sat <= (err_cnt == ERR_NEAR);
        end
      end
    end
  end

endmodule

// File: rtl/bert_rx_sync_chk.sv
module bert_rx_sync_chk #(
  parameter int BIT_CNT_W = 32,
  parameter int ERR_CNT_W = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bit_vld,
  input logic                 bit_in,
  input logic                 cnt_clr,
  input logic                 in_sync,
  input logic                 search_start,
  input logic                 err_det,
  input logic                 bit_sat,
  input logic                 err_sat,
  input logic                 all_zeros,
  input logic [BIT_CNT_W-1:0] bit_cnt,
  input logic [ERR_CNT_W-1:0] err_cnt
);

  AST_LOCK_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> $past(bit_vld)); // R3

  AST_ERR_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    err_det |-> $past(in_sync) && $past(bit_vld)); // R4

  AST_LOSS_SEARCHES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sync) |-> search_start); // R5

  AST_ERRCNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_det && !$past(cnt_clr)) |-> $stable(err_cnt)); // R6

  AST_ERR_SAT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_sat |-> err_det && (err_cnt == '1)); // R6

  AST_BIT_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == '1 && !cnt_clr) |=> (bit_cnt == '1) && !bit_sat); // R7

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (bit_cnt == '0) && (err_cnt == '0)); // R8

  AST_ONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && bit_in) |=> !all_zeros); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !cnt_clr) |=> $stable(in_sync) && $stable(bit_cnt) && $stable(all_zeros)); // R10

endmodule

bind bert_rx_sync bert_rx_sync_chk #(
  .BIT_CNT_W(BIT_CNT_W),
  .ERR_CNT_W(ERR_CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .cnt_clr(cnt_clr),
  .in_sync(in_sync), .search_start(search_start), .err_det(err_det),
  .bit_sat(bit_sat), .err_sat(err_sat), .all_zeros(all_zeros),
  .bit_cnt(bit_cnt), .err_cnt(err_cnt)
);

// File: tb/bert_rx_sync_tb.sv
`timescale 1ns/1ps
module bert_rx_sync_tb;
  localparam int BW = 12;
  localparam int EW = 6;
  localparam int BMAX = (1 << BW) - 1;
  localparam int EMAX = (1 << EW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0, bit_in = 1'b0, cnt_clr = 1'b0;
  logic in_sync, search_start, err_det, bit_sat, err_sat, all_zeros;
  logic [BW-1:0] bit_cnt;
  logic [EW-1:0] err_cnt;

  always #4 clk = ~clk;

  bert_rx_sync #(.BIT_CNT_W(BW), .ERR_CNT_W(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .cnt_clr(cnt_clr),
    .in_sync(in_sync), .search_start(search_start), .err_det(err_det),
    .bit_sat(bit_sat), .err_sat(err_sat), .all_zeros(all_zeros),
    .bit_cnt(bit_cnt), .err_cnt(err_cnt));

  typedef struct packed {
    logic sync, ss, ed, bs, es, az;
    logic [BW-1:0] bc;
    logic [EW-1:0] ec;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0;
  logic [14:0] m_ref = '0;
  logic [14:0] tx = 15'h0001;
  bit   m_win[$];
  bit   m_sync = 0, m_boot = 1;
  int   m_run = 0, m_zr = 0, m_bits = 0, m_errs = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic apply(bit v, bit b, bit clr);
    exp_t e;
    bit p;
    int s;
    bit_vld = v; bit_in = b; cnt_clr = clr;
    p = m_ref[14] ^ m_ref[13];
    e = '0;
    e.ss = m_boot; m_boot = 0;
    if (clr) begin m_bits = 0; m_errs = 0; end
    if (v) begin
      if (!clr && m_bits != BMAX) begin m_bits++; if (m_bits == BMAX) e.bs = 1; end
      m_zr = b ? 0 : (m_zr < 31 ? m_zr + 1 : 31);
      if (m_sync) begin
        m_win.push_back(b != p);
        if (m_win.size() > 64) void'(m_win.pop_front());
        s = 0;
        foreach (m_win[i]) s += int'(m_win[i]);
        if (b != p) begin
          e.ed = 1;
          if (!clr && m_errs != EMAX) begin m_errs++; if (m_errs == EMAX) e.es = 1; end
        end
        m_ref = {m_ref[13:0], p};
        if (s >= 6) begin m_sync = 0; m_run = 0; m_win.delete(); e.ss = 1; end
      end else begin
        m_ref = {m_ref[13:0], b};
        m_run = (b == p) ? m_run + 1 : 0;
        if (m_run == 32) begin m_sync = 1; m_run = 0; m_win.delete(); end
      end
    end
    e.sync = m_sync; e.az = (m_zr == 31);
    e.bc = BW'(m_bits); e.ec = EW'(m_errs);
    q.push_back(e);
  endtask

  task automatic step(bit v, bit b, bit clr);
    @(negedge clk);
    apply(v, b, clr);
  endtask

  task automatic send_prbs(int n, int period, int nerr);
    int done = 0;
    for (int i = 0; i < n; i++) begin
      bit nb, fl;
      nb = tx[14] ^ tx[13];
      tx = {tx[13:0], nb};
      fl = (period > 0) && (i % period == period - 1) && (nerr < 0 || done < nerr);
      if (fl) done++;
      step(1, nb ^ fl, 0);
    end
  endtask

  task automatic settle;
    @(posedge clk); #3;
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R3", "in_sync", 64'(in_sync), 64'(e.sync));
      chk("R5", "search_start", 64'(search_start), 64'(e.ss));
      chk("R4", "err_det", 64'(err_det), 64'(e.ed));
      chk("R7", "bit_sat", 64'(bit_sat), 64'(e.bs));
      chk("R6", "err_sat", 64'(err_sat), 64'(e.es));
      chk("R9", "all_zeros", 64'(all_zeros), 64'(e.az));
      chk("R7", "bit_cnt", 64'(bit_cnt), 64'(e.bc));
      chk("R6", "err_cnt", 64'(err_cnt), 64'(e.ec));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [EW-1:0] saved_e;
    logic [BW-1:0] saved_b;
    repeat (4) @(posedge clk);
    #3;
    // R1: state held in reset
    chk("R1", "reset in_sync", 64'(in_sync), 0);
    chk("R1", "reset counters", 64'({bit_cnt, err_cnt}), 0);
    chk("R1", "reset flags", 64'({search_start, err_det, bit_sat, err_sat, all_zeros}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(0, 0, 0);

    // R9: 30 zeros, idle gap, 31st zero, idle gap, then a one
    for (int i = 0; i < 30; i++) step(1, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0);
    step(1, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0);
    settle();
    chk("R9", "all_zeros after 31 zeros", 64'(all_zeros), 1);
    step(1, 1, 0);
    settle();
    chk("R9", "all_zeros after a one", 64'(all_zeros), 0);

    // R2 R3: clean sequence self-seeds and locks
    send_prbs(100, 0, 0);
    settle();
    chk("R2", "locked on clean sequence", 64'(in_sync), 1);

    // R5: five errors within 64 bits keep lock
    send_prbs(60, 10, 5);
    send_prbs(80, 0, 0);
    settle();
    chk("R5", "lock kept with 5 errors", 64'(in_sync), 1);
    send_prbs(70, 10, 6);
    settle();
    chk("R5", "lock lost with 6 errors", 64'(in_sync), 0);

    // R6: random bits while searching add no errors
    saved_e = err_cnt;
    for (int i = 0; i < 150; i++) step(1, 1'($urandom), 0);
    settle();
    chk("R6", "no error counting while searching", 64'(err_cnt), 64'(saved_e));

    send_prbs(100, 0, 0);
    settle();
    chk("R3", "relocked", 64'(in_sync), 1);

    // R10: idle cycles change nothing
    saved_b = bit_cnt;
    for (int i = 0; i < 20; i++) step(0, 1, 0);
    settle();
    chk("R10", "bit_cnt stable while idle", 64'(bit_cnt), 64'(saved_b));
    chk("R10", "lock stable while idle", 64'(in_sync), 1);

    // R6 R7: saturation with sparse errors
    send_prbs(1100, 16, -1);
    settle();
    chk("R6", "err_cnt saturated", 64'(err_cnt), EMAX);
    chk("R5", "sparse errors keep lock", 64'(in_sync), 1);
    send_prbs(2600, 0, 0);
    settle();
    chk("R7", "bit_cnt saturated", 64'(bit_cnt), BMAX);

    // R8: clear and saturate again
    step(0, 0, 1);
    step(0, 0, 0);
    settle();
    chk("R8", "bit_cnt cleared", 64'(bit_cnt), 0);
    chk("R8", "err_cnt cleared", 64'(err_cnt), 0);
    send_prbs(1100, 16, -1);
    settle();
    chk("R8", "err_cnt saturates again", 64'(err_cnt), EMAX);

    step(0, 0, 0);
    repeat (3) @(posedge clk);
    #3;
    chk("R1", "scoreboard drained", 64'(q.size()), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule